// File: doc/BRIEF.md
# Parallel Port Host Register Block

This block gives a host processor the three byte-wide registers of a standard PC printer port: a data register, a status register and a control register. It sits in an eight-byte window of a simple synchronous register bus. The block does not drive port pins. Instead it models the printer's side of the strobe, busy and acknowledge exchange internally. Each completed strobe hands the written byte to an output valid/data pair.

Software drives the port the usual way. It writes a byte, pulses strobe through the control register, and polls status. Each status poll moves the modelled acknowledge and busy lines one step. If software has enabled the interrupt, a falling strobe with the port selected and out of initialisation raises a level interrupt. The next status read clears that interrupt. In read direction the data register returns a byte latched from an external input.

Top module: `pp_host_if`

## Requirements
- R1: After reset the data register reads 0xFF, the status register reads 0xD9, the control register reads 0xCC, `irq` is 0 and `out_valid` is 0.
- R2: Only address bits [2:0] are decoded; offsets 0, 1 and 2 are data, status and control. Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register.
- R3: A data read returns the input latch when control bit 5 (direction) is 1, and the last written data byte when it is 0.
- R4: Every control write stores the written value with bits 7 and 6 forced to 1, and a control read returns that stored value.
- R5: A control write with bit 2 (init) at 0 sets the status to 0xD8 (bits 7 busy-inverted, 6 ack, 4 online and 3 error-inverted high, all other bits low).
- R6: A control write with bits 2, 3 and 0 (init, select, strobe) all at 1 clears status bit 7. If the stored strobe bit was 0 before this write, `out_valid` is high for exactly the next cycle with `out_byte` equal to the data register.
- R7: A control write with init and select at 1 and strobe at 0 sets the interrupt-pending flag when the stored bit 4 (interrupt enable) was 1 before the write. `irq` follows the flag from the cycle after the write.
- R8: A status read returns the status value as it was before the read, and clears the interrupt-pending flag, so `irq` is 0 from the next cycle.
- R9: After a status read, if status bit 7 is 0 and the stored strobe bit is 0, the handshake advances. When status bit 6 (ack) was 1 it is cleared. Otherwise bits 7 and 6 are both set.
- R10: When `in_load` is high, the input latch takes `in_byte` at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | BUS_AW | Byte address; only bits [2:0] are decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while `bus_rd` is high, 0 otherwise |
| in_load | input | 1 | Load strobe for the input-data latch |
| in_byte | input | 8 | Byte loaded into the input-data latch |
| out_valid | output | 1 | One-cycle pulse: a byte was strobed out |
| out_byte | output | 8 | Byte handed out with `out_valid` |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is the acknowledge toggle. It needs busy low and the stored strobe low at the same moment. Busy only falls on a strobe-high control write, and the toggle only runs after the strobe has been written low again. The vector table walks that exact sequence: init, strobe low, strobe high, strobe low. It then issues repeated status reads and checks the values 0x58, 0x18 and 0xD8 in turn. For the interrupt, interrupt enable must already be stored before a second strobe-low write, so the same control value is written twice and `irq` is checked after each write.

// File: rtl/pp_pkg.sv
// Package: shared bit positions, offsets and reset constants of the
// parallel port host register block.
package pp_pkg;

    typedef logic [7:0] pp_byte_t;

    // Register offsets inside the eight-byte window.
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;

    // Status bit positions.
    localparam int ST_BUSY_N = 7;
    localparam int ST_ACK    = 6;

    // Control bit positions.
    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_STB  = 0;

    localparam pp_byte_t CTRL_FORCE  = 8'hC0;
    localparam pp_byte_t STAT_RESET  = 8'hD9;
    localparam pp_byte_t STAT_INIT   = 8'hD8;
    localparam pp_byte_t CTRL_RESET  = 8'hCC;
    localparam pp_byte_t DATA_RESET  = 8'hFF;
    localparam pp_byte_t EMPTY_READ  = 8'hFF;

endpackage

// File: rtl/pp_decode.sv
// Address decoder: turns the bus strobes and the low address bits into
// one-hot access strobes per register. Assumes at most one of wr/rd per cycle.
module pp_decode #(
    parameter int BUS_AW = 8,
    localparam int OFS_W = 3
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [BUS_AW-1:0] addr,
    output logic [OFS_W-1:0]  ofs,
    output logic              wr_data,
    output logic              wr_ctrl,
    output logic              rd_stat
);
    import pp_pkg::*;

    // Keep only the window offset; higher bits are ignored.
    always_comb begin
        ofs     = addr[OFS_W-1:0];
        wr_data = wr && (ofs == OFS_DATA);
        wr_ctrl = wr && (ofs == OFS_CTRL);
        rd_stat = rd && (ofs == OFS_STAT);
    end

endmodule

// File: rtl/pp_handshake.sv
// Printer-side handshake model: owns the status register and the
// interrupt-pending flag, and requests a byte emission on a strobe edge.
// Assumes ctrl_new already carries the forced-high bits 7:6.
module pp_handshake (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ctrl,
    input  pp_pkg::pp_byte_t ctrl_new,
    input  pp_pkg::pp_byte_t ctrl_old,
    input  logic            rd_stat,
    output pp_pkg::pp_byte_t status,
    output logic            pending,
    output logic            emit
);
    import pp_pkg::*;

    logic active;
    logic stb_hi_wr;
    logic stb_lo_wr;
    logic toggle_ok;

    // Classify the control write and the status-read advance condition.
    always_comb begin
        active    = wr_ctrl && ctrl_new[CT_INIT] && ctrl_new[CT_SEL];
        stb_hi_wr = active && ctrl_new[CT_STB];
        stb_lo_wr = active && !ctrl_new[CT_STB];
        emit      = stb_hi_wr && !ctrl_old[CT_STB];
        toggle_ok = rd_stat && !status[ST_BUSY_N] && !ctrl_old[CT_STB];
    end

    // Status register: init, strobe and read-driven handshake steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= STAT_RESET;
        end else if (wr_ctrl && !ctrl_new[CT_INIT]) begin
            status <= STAT_INIT;
        end else if (stb_hi_wr) begin
            status[ST_BUSY_N] <= 1'b0;
        end else if (toggle_ok) begin
            if (status[ST_ACK]) begin
                status[ST_ACK] <= 1'b0;
            end else begin
                status[ST_ACK]    <= 1'b1;
                status[ST_BUSY_N] <= 1'b1;
            end
        end
    end

    // Interrupt-pending flag: set by an enabled strobe-low write, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (stb_lo_wr && ctrl_old[CT_IEN]) begin
            pending <= 1'b1;
        end else if (rd_stat) begin
            pending <= 1'b0;
        end
    end

    assert_init_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !ctrl_new[CT_INIT]) |=> (status == STAT_INIT));

    assert_busy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && ctrl_new[CT_INIT] && ctrl_new[CT_SEL] && ctrl_new[CT_STB])
        |=> !status[ST_BUSY_N]);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !wr_ctrl) |=> !pending);

    assert_pending_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctrl && !rd_stat) |=> $stable(pending));

endmodule

// File: rtl/pp_rdmux.sv
// Read multiplexer: selects the register addressed by the window offset.
// Output is zero when no read is in progress.
module pp_rdmux (
    input  logic            rd,
    input  logic [2:0]      ofs,
    input  pp_pkg::pp_byte_t data_wr,
    input  pp_pkg::pp_byte_t data_in,
    input  pp_pkg::pp_byte_t status,
    input  pp_pkg::pp_byte_t control,
    output pp_pkg::pp_byte_t rdata
);
    import pp_pkg::*;

    // Pick the addressed register; unimplemented offsets read all ones.
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (ofs)
                OFS_DATA: rdata = control[CT_DIR] ? data_in : data_wr;
                OFS_STAT: rdata = status;
                OFS_CTRL: rdata = control;
                default:  rdata = EMPTY_READ;
            endcase
        end
    end

endmodule

// File: rtl/pp_host_if.sv
// Parallel port host register block: data latches, control register,
// byte output pulse and interrupt line around the handshake model.
// Assumes one bus access per cycle; reset is synchronous, active low.
module pp_host_if #(
    parameter int BUS_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              in_load,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              irq
);
    import pp_pkg::*;

    logic [2:0] ofs;
    logic       wr_data;
    logic       wr_ctrl;
    logic       rd_stat;
    pp_byte_t   data_wr_q;
    pp_byte_t   data_in_q;
    pp_byte_t   ctrl_q;
    pp_byte_t   ctrl_new;
    pp_byte_t   status;
    logic       pending;
    logic       emit;

    pp_decode #(.BUS_AW(BUS_AW)) u_decode (
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .ofs     (ofs),
        .wr_data (wr_data),
        .wr_ctrl (wr_ctrl),
        .rd_stat (rd_stat)
    );

    // Control value as it will be stored: top two bits forced high.
    always_comb ctrl_new = bus_wdata | CTRL_FORCE;

    pp_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .ctrl_new (ctrl_new),
        .ctrl_old (ctrl_q),
        .rd_stat  (rd_stat),
        .status   (status),
        .pending  (pending),
        .emit     (emit)
    );

    pp_rdmux u_rdmux (
        .rd      (bus_rd),
        .ofs     (ofs),
        .data_wr (data_wr_q),
        .data_in (data_in_q),
        .status  (status),
        .control (ctrl_q),
        .rdata   (bus_rdata)
    );

    // Written data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_wr_q <= DATA_RESET;
        else if (wr_data) data_wr_q <= bus_wdata;
    end

    // Input-data latch loaded from the external byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_in_q <= DATA_RESET;
        else if (in_load) data_in_q <= in_byte;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (wr_ctrl) ctrl_q <= ctrl_new;
    end

    // Byte output pulse registered on the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) out_byte <= data_wr_q;
        end
    end

    // Interrupt line is the registered pending flag.
    always_comb irq = pending;

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_ctrl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[2:0] == OFS_CTRL) |-> (bus_rdata[7:6] == 2'b11));

    assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[2:0] > OFS_CTRL) |-> (bus_rdata == EMPTY_READ));

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_load |=> (data_in_q == $past(in_byte)));

endmodule

// File: tb/pp_host_if_bench.sv
module pp_host_if_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       in_load = 1'b0;
    logic [7:0] in_byte = '0;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic       last_pulse;
    logic [7:0] last_byte;
    logic [7:0] rv;

    always #4 clk = ~clk;

    pp_host_if #(.BUS_AW(8)) u_pp_host_if (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_load(in_load), .in_byte(in_byte), .out_valid(out_valid),
        .out_byte(out_byte), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Write one register; records the output pulse seen in the next cycle.
    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_pulse = out_valid;
        last_byte  = out_byte;
    endtask

    // Read one register; sample before the edge that applies side effects.
    task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // {is_read, addr, value, expected}; for writes expected[0] is the pulse.
    localparam int NV = 17;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h01, 8'h00, 8'hD9},  // R1 reset status, busy high: no toggle
        {1'b0, 8'h02, 8'h08, 8'h00},  // R5 init low
        {1'b1, 8'h01, 8'h00, 8'hD8},  // R5
        {1'b0, 8'h00, 8'h5A, 8'h00},  // data write
        {1'b1, 8'h00, 8'h00, 8'h5A},  // R3 dir 0 returns written byte
        {1'b0, 8'h02, 8'h0C, 8'h00},  // strobe low, no emission
        {1'b0, 8'h02, 8'h0D, 8'h01},  // R6 strobe rises: emit
        {1'b1, 8'h01, 8'h00, 8'h58},  // R6 busy cleared; strobe stored high
        {1'b0, 8'h02, 8'h0C, 8'h00},  // strobe low again
        {1'b1, 8'h01, 8'h00, 8'h58},  // R9 read then ack clears
        {1'b1, 8'h01, 8'h00, 8'h18},  // R9 read then ack+busy set
        {1'b1, 8'h01, 8'h00, 8'hD8},  // R9 busy high: stable
        {1'b1, 8'h01, 8'h00, 8'hD8},  // R9
        {1'b1, 8'h02, 8'h00, 8'hCC},  // R4 forced bits
        {1'b1, 8'h03, 8'h00, 8'hFF},  // R2 empty offset
        {1'b1, 8'h07, 8'h00, 8'hFF},  // R2 empty offset
        {1'b1, 8'hFA, 8'h00, 8'hCC}   // R2 high address bits ignored
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 out_valid", {7'd0, out_valid}, 8'h00);
        do_rd(8'h00, rv); check("R1 data", rv, 8'hFF);
        do_rd(8'h02, rv); check("R1 control", rv, 8'hCC);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) begin
                do_rd(VEC[i][23:16], rv);
                check($sformatf("vector %0d R2/R3/R4/R5/R6/R9 read", i), rv, VEC[i][7:0]);
            end else begin
                do_wr(VEC[i][23:16], VEC[i][15:8]);
                check($sformatf("vector %0d R6 pulse", i), {7'd0, last_pulse}, {7'd0, VEC[i][0]});
                if (VEC[i][0]) check("R6 out_byte", last_byte, 8'h5A);
            end
        end

        // R6 pulse lasts one cycle only
        do_wr(8'h02, 8'h0C);
        do_wr(8'h02, 8'h0D);
        check("R6 pulse first", {7'd0, last_pulse}, 8'h01);
        @(negedge clk);
        check("R6 pulse ends", {7'd0, out_valid}, 8'h00);
        // R6 strobe already high: no second emission
        do_wr(8'h02, 8'h0D);
        check("R6 no repeat", {7'd0, last_pulse}, 8'h00);

        // R7 enable stored only after first write
        do_wr(8'h02, 8'h1C);
        check("R7 enable not yet stored", {7'd0, irq}, 8'h00);
        do_wr(8'h02, 8'h1C);
        check("R7 irq set", {7'd0, irq}, 8'h01);
        do_rd(8'h01, rv);
        check("R8 irq cleared", {7'd0, irq}, 8'h00);
        // R7 enable with init low: no interrupt
        do_wr(8'h02, 8'h18);
        do_wr(8'h02, 8'h18);
        check("R7 init low no irq", {7'd0, irq}, 8'h00);

        // R2 writes to status and empty offsets leave registers unchanged
        do_wr(8'h02, 8'h0C);
        do_wr(8'h00, 8'h33);
        do_wr(8'h0B, 8'h99);
        do_wr(8'h01, 8'h00);
        do_wr(8'h0D, 8'h00);
        do_rd(8'h00, rv); check("R2 data unchanged", rv, 8'h33);
        do_rd(8'h02, rv); check("R2 control unchanged", rv, 8'hCC);

        // R3/R10 read direction returns input latch
        do_wr(8'h02, 8'h2C);
        do_rd(8'h00, rv); check("R3 input latch reset", rv, 8'hFF);
        @(negedge clk); in_load = 1'b1; in_byte = 8'h3C;
        @(negedge clk); in_load = 1'b0; in_byte = 8'h00;
        do_rd(8'h00, rv); check("R10 loaded", rv, 8'h3C);
        do_rd(8'h02, rv); check("R4 dir stored", rv, 8'hEC);
        do_wr(8'h02, 8'h0C);
        do_rd(8'h00, rv); check("R3 back to written byte", rv, 8'h33);

        // R1 reset in the middle of activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_rd(8'h01, rv); check("R1 status after reset", rv, 8'hD9);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule